// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block provides two independent 16-bit up-counting time bases and a small array of capture/compare channels (four by default). Each time base advances by one on every tick of its own prescaler, which divides the system clock by 1, 2, 4 or 8. When a time base passes its all-ones value, it restarts from its reload register. Each channel is tied to one of the two time bases and is set up either to record the time of an edge on its input pin or to act when the time base reaches the value in the channel register.

A channel in capture mode watches its input pin through a two-flop synchronizer. It copies the current value of its time base on a rising edge, a falling edge or on both. In compare mode the channel can raise its flag on every match, toggle its pin on every match, raise its flag once per time-base period, or drive its pin high on the first match of a period and low again at overflow. Two neighbouring channels (an even channel and the odd one above it) can be paired so that either register toggles the even pin. A match is evaluated only in a cycle in which the time base has just advanced.

Once-per-period behaviour is held in a two-state machine per channel. `ST_ARMED` moves to `ST_SPENT` on the first acting match in a once mode. `ST_SPENT` returns to `ST_ARMED` on an overflow of the assigned time base or on a write to the channel's configuration. An overflow that coincides with a match leaves the channel in `ST_SPENT`, because that match belongs to the new period. A configuration write keeps or puts the channel in `ST_ARMED`.

Top module: `ccu_unit`

## Requirements
- R1: After reset, every register reads 0, and all pins and flags are 0.
- R2: A running time base advances by one every 2^sel clock cycles, where sel (0..3) is its prescaler select. A stopped time base holds its value.
- R3: When a time base advances from 0xFFFF, it loads its reload register in place of wrapping to 0.
- R4: Configuration mode codes 1, 2 and 3 capture on a rising edge, a falling edge or either edge. A capture copies the assigned time base into the channel register and sets the channel flag. The register changes on the third rising clock edge after the pin changes. An edge of the other polarity has no effect.
- R5: Configuration bit 3 selects the time base of a channel (0: first, 1: second).
- R6: Mode code 4 sets the flag on every match.
- R7: Mode code 5 toggles the pin and sets the flag on every match.
- R8: Mode code 6 sets the flag on the first match of a time-base period only. A second match within the same period does nothing.
- R9: Mode code 7 drives the pin to 1 and sets the flag on the first match of a period, and drives the pin to 0 on overflow. A match in the same cycle as the overflow wins, and the pin is 1.
- R10: When configuration bit 4 of an even channel is set, the even pin toggles on a match with either that channel or the next odd channel. It toggles only once if both match in the same cycle, and the odd pin holds.
- R11: A time base that does not advance causes no compare action, even while it equals a channel register.
- R12: Writing to the flag address clears the flags whose data bits are 1 and leaves the others.
- R13: Register addresses are as follows. Addresses 0 and 1 hold the two counts, and 2 and 3 the two reload registers. Addresses 4+i hold channel registers and 4+N+i the 5-bit configurations (bits 2:0 mode, bit 3 time base, bit 4 pairing). Address 4+2N reads the flags. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_run | input | 2 | Run enable per time base |
| pre_sel0 | input | PSW | Prescaler select of time base 0 (divide by 2^sel) |
| pre_sel1 | input | PSW | Prescaler select of time base 1 |
| cc_in | input | N | Channel input pins (capture) |
| cc_out | output | N | Channel output pins (compare) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | TW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | TW | Register read data (combinational) |
| irq | output | N | Sticky per-channel interrupt flags |

## Verification
Two things can fall in the same cycle: a time-base overflow and a compare match on the reloaded value. To provoke this, a mode-7 channel register is set equal to the reload value and the count is started two steps below the wrap point. The pin must read 1 after the reload, because a lost match would leave it at 0. The same concern applies to paired channels, which are given equal registers so that both match at once. The shared pin must change exactly once in that case.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;
    typedef enum logic [2:0] {
        M_OFF        = 3'd0,
        M_CAP_RISE   = 3'd1,
        M_CAP_FALL   = 3'd2,
        M_CAP_BOTH   = 3'd3,
        M_CMP_FLAG   = 3'd4,
        M_CMP_TOGGLE = 3'd5,
        M_CMP_ONCE   = 3'd6,
        M_CMP_SETCLR = 3'd7
    } mode_e;

    typedef enum logic {ST_ARMED = 1'b0, ST_SPENT = 1'b1} arm_e;

    typedef struct packed {
        logic  pair;
        logic  tsel;
        mode_e mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/ccu_timebase.sv
`timescale 1ns/1ps
module ccu_timebase #(
    parameter int TW  = 16,
    parameter int PSW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PSW-1:0] sel,
    input  logic          wr_cnt,
    input  logic          wr_rl,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] cnt,
    output logic [TW-1:0] rl,
    output logic          adv,
    output logic          ovf
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] pre_q;
    logic [PCW-1:0] mask;
    logic           tick;

    always_comb begin
        mask = ~({PCW{1'b1}} << sel);
        tick = (pre_q & mask) == '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rl  <= '0;
            adv <= 1'b0;
            ovf <= 1'b0;
        end else begin
            adv <= 1'b0;
            ovf <= 1'b0;
            if (wr_rl) rl <= wr_data;
            if (wr_cnt) begin
                cnt <= wr_data;
            end else if (run && tick) begin
                adv <= 1'b1;
                if (cnt == {TW{1'b1}}) begin
                    cnt <= rl;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ccu_channel.sv
`timescale 1ns/1ps
module ccu_channel import ccu_pkg::*; #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          rearm,
    input  logic          pin_in,
    input  logic [TW-1:0] tcnt,
    input  logic          tadv,
    input  logic          tovf,
    input  logic          wr_val,
    input  logic [TW-1:0] wr_data,
    input  logic          pair_lead,
    input  logic          pair_follow,
    input  logic          partner_hit,
    output logic [TW-1:0] val,
    output logic          pin_out,
    output logic          hit,
    output logic          evt
);
    arm_e       st_q, st_d;
    logic [2:0] sync_q;
    logic       rise, fall, cap_evt, is_cmp, once, fire;

    always_comb begin
        rise    = sync_q[1] & ~sync_q[2];
        fall    = ~sync_q[1] & sync_q[2];
        cap_evt = ((cfg.mode == M_CAP_RISE) && rise) ||
                  ((cfg.mode == M_CAP_FALL) && fall) ||
                  ((cfg.mode == M_CAP_BOTH) && (rise || fall));
        is_cmp  = cfg.mode[2];
        once    = (cfg.mode == M_CMP_ONCE) || (cfg.mode == M_CMP_SETCLR);
        hit     = is_cmp && tadv && (tcnt == val);
        fire    = hit && (!once || st_q == ST_ARMED || tovf);
        evt     = fire || cap_evt;
    end

    // next state of the once-per-period arming
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARMED: if (!rearm && once && fire) st_d = ST_SPENT;
            ST_SPENT: begin
                if (rearm)                         st_d = ST_ARMED;
                else if (tovf && !(once && fire))  st_d = ST_ARMED;
            end
            default: st_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ARMED;
        else        st_q <= st_d;
    end

    // outputs: synchronizer, channel register, pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '0;
            val     <= '0;
            pin_out <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], pin_in};
            if (wr_val)       val <= wr_data;
            else if (cap_evt) val <= tcnt;
            if (pair_follow) begin
                pin_out <= pin_out;
            end else if (pair_lead) begin
                if (hit || partner_hit) pin_out <= ~pin_out;
            end else begin
                unique case (cfg.mode)
                    M_CMP_TOGGLE: if (fire) pin_out <= ~pin_out;
                    M_CMP_SETCLR: begin
                        if (fire)      pin_out <= 1'b1;
                        else if (tovf) pin_out <= 1'b0;
                    end
                    default: pin_out <= pin_out;
                endcase
            end
        end
    end
endmodule

// File: rtl/ccu_unit.sv
`timescale 1ns/1ps
module ccu_unit import ccu_pkg::*; #(
    parameter int N   = 4,
    parameter int TW  = 16,
    parameter int PSW = 2,
    parameter int AW  = $clog2(4 + 2*N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     tmr_run,
    input  logic [PSW-1:0] pre_sel0,
    input  logic [PSW-1:0] pre_sel1,
    input  logic [N-1:0]   cc_in,
    output logic [N-1:0]   cc_out,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [TW-1:0]  rd_data,
    output logic [N-1:0]   irq
);
    localparam int NP = N / 2;
    localparam logic [AW-1:0] A_FLAG = AW'(4 + 2*N);

    logic [TW-1:0]  tcnt [2];
    logic [TW-1:0]  trl  [2];
    logic [1:0]     tadv, tovf;
    logic [PSW-1:0] tsel [2];
    cfg_t           cfg_q [N];
    logic [TW-1:0]  cval [N];
    logic [N-1:0]   hit_w, evt_w, flags, clr;
    logic [NP-1:0]  pair_en;

    assign tsel[0] = pre_sel0;
    assign tsel[1] = pre_sel1;

    for (genvar t = 0; t < 2; t++) begin : g_tb
        ccu_timebase #(.TW(TW), .PSW(PSW)) u_tb (
            .clk(clk), .rst_n(rst_n), .run(tmr_run[t]), .sel(tsel[t]),
            .wr_cnt(wr_en && wr_addr == AW'(t)),
            .wr_rl(wr_en && wr_addr == AW'(2 + t)),
            .wr_data(wr_data), .cnt(tcnt[t]), .rl(trl[t]),
            .adv(tadv[t]), .ovf(tovf[t])
        );
    end

    for (genvar p = 0; p < NP; p++) begin : g_pair
        assign pair_en[p] = cfg_q[2*p].pair;
    end

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam bit EVEN = (i % 2) == 0;
        localparam int LEAD = i - (i % 2);
        localparam int PART = EVEN ? i + 1 : i - 1;
        localparam logic [AW-1:0] A_VAL = AW'(4 + i);
        localparam logic [AW-1:0] A_CFG = AW'(4 + N + i);
        logic cfg_wr;

        assign cfg_wr = wr_en && wr_addr == A_CFG;

        always_ff @(posedge clk) begin
            if (!rst_n)      cfg_q[i] <= '0;
            else if (cfg_wr) cfg_q[i] <= cfg_t'(wr_data[CFG_W-1:0]);
        end

        ccu_channel #(.TW(TW)) u_ch (
            .clk(clk), .rst_n(rst_n), .cfg(cfg_q[i]), .rearm(cfg_wr),
            .pin_in(cc_in[i]),
            .tcnt(cfg_q[i].tsel ? tcnt[1] : tcnt[0]),
            .tadv(cfg_q[i].tsel ? tadv[1] : tadv[0]),
            .tovf(cfg_q[i].tsel ? tovf[1] : tovf[0]),
            .wr_val(wr_en && wr_addr == A_VAL), .wr_data(wr_data),
            .pair_lead(EVEN && cfg_q[i].pair),
            .pair_follow(!EVEN && cfg_q[LEAD].pair),
            .partner_hit(hit_w[PART]),
            .val(cval[i]), .pin_out(cc_out[i]), .hit(hit_w[i]), .evt(evt_w[i])
        );
    end

    assign clr = (wr_en && wr_addr == A_FLAG) ? wr_data[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | evt_w;
    end

    assign irq = flags;

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < 2; t++) begin
            if (rd_addr == AW'(t))     rd_data = tcnt[t];
            if (rd_addr == AW'(2 + t)) rd_data = trl[t];
        end
        for (int i = 0; i < N; i++) begin
            if (rd_addr == AW'(4 + i))     rd_data = cval[i];
            if (rd_addr == AW'(4 + N + i)) rd_data = TW'(cfg_q[i]);
        end
        if (rd_addr == A_FLAG) rd_data = TW'(flags);
    end
endmodule

// File: rtl/ccu_unit_chk.sv
`timescale 1ns/1ps
module ccu_unit_chk #(
    parameter int N  = 4,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    tmr_run,
    input logic [TW-1:0] cnt0,
    input logic [TW-1:0] cnt1,
    input logic [TW-1:0] rl0,
    input logic [TW-1:0] rl1,
    input logic [1:0]    adv,
    input logic [1:0]    ovf,
    input logic [N/2-1:0] pair_en,
    input logic [N-1:0]  cc_out
);
    AST_ADV_NEEDS_RUN0: assert property (@(posedge clk) disable iff (!rst_n)
        adv[0] |-> $past(tmr_run[0])); // R2
    AST_STEP_ONE0: assert property (@(posedge clk) disable iff (!rst_n)
        (adv[0] && !ovf[0]) |-> cnt0 == $past(cnt0) + TW'(1)); // R2
    AST_WRAP_RELOAD0: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] |-> cnt0 == $past(rl0)); // R3
    AST_WRAP_RELOAD1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[1] |-> cnt1 == $past(rl1)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_run, 2) == 2'b00) |-> $stable(cc_out)); // R11

    for (genvar p = 0; p < N/2; p++) begin : g_pair
        AST_FOLLOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pair_en[p]) |-> $stable(cc_out[2*p+1])); // R10
    end
endmodule

bind ccu_unit ccu_unit_chk #(.N(N), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_run(tmr_run),
    .cnt0(tcnt[0]), .cnt1(tcnt[1]), .rl0(trl[0]), .rl1(trl[1]),
    .adv(tadv), .ovf(tovf), .pair_en(pair_en), .cc_out(cc_out)
);

// File: tb/ccu_unit_tb.sv
`timescale 1ns/1ps
module ccu_unit_tb;
    localparam int N = 4, TW = 16, PSW = 2, AW = 4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] tmr_run = '0;
    logic [PSW-1:0] pre_sel0 = '0, pre_sel1 = '0;
    logic [N-1:0] cc_in = '0, cc_out, irq;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [TW-1:0] wr_data = '0, rd_data, got;
    int checks = 0, fails = 0;
    bit done = 0, p0, p1, p3;

    always #2.5 clk = ~clk;

    ccu_unit u_dut (.*);

    localparam int NV = 10;
    localparam logic [AW-1:0] VA [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8, 4'd11, 4'd12, 4'd13};
    localparam logic [TW-1:0] VD [NV] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'hA5A5, 16'h1111,
                                          16'h7777, 16'h00FF, 16'h0015, 16'h000F, 16'hFFFF};
    localparam logic [TW-1:0] VE [NV] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'hA5A5, 16'h1111,
                                          16'h7777, 16'h001F, 16'h0015, 16'h0000, 16'h0000};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [TW-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic run(input int idx, input int n, input logic [PSW-1:0] sel);
        if (idx == 0) pre_sel0 = sel; else pre_sel1 = sel;
        tmr_run[idx] = 1'b1;
        repeat (n) @(negedge clk);
        tmr_run[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int a = 0; a < 13; a++) begin
            rd(AW'(a), got);
            chk(got == 0, "R1 reg", got, 0);
        end
        chk(cc_out == 0 && irq == 0, "R1 pins/flags", {cc_out, irq}, 0);

        // R13: register map via table
        for (int v = 0; v < NV; v++) begin
            wr(VA[v], VD[v]);
            rd(VA[v], got);
            chk(got == VE[v], "R13 map", got, VE[v]);
        end
        do_reset();

        // R2: prescaler and stall
        wr(0, 16'h0000);
        run(0, 40, 2'd2);
        rd(0, got); chk(got == 16'd10, "R2 div4", got, 10);
        run(1, 7, 2'd0);
        rd(1, got); chk(got == 16'd7, "R2 div1", got, 7);
        rd(0, got); chk(got == 16'd10, "R2 stopped holds", got, 10);

        // R3: reload on wrap
        wr(2, 16'h1234); wr(0, 16'hFFFE);
        run(0, 3, 2'd0);
        rd(0, got); chk(got == 16'h1235, "R3 reload", got, 16'h1235);

        // R4/R5: capture, second time base, latency
        wr(8, 16'h0009); wr(1, 16'h0ABC);
        cc_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(4, got); chk(got == 16'h0000, "R4 latency early", got, 0);
        @(negedge clk);
        rd(4, got); chk(got == 16'h0ABC, "R4 R5 capture rise t1", got, 16'h0ABC);
        chk(irq[0] == 1'b1, "R4 flag", irq, 1);
        wr(1, 16'h0111); cc_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h0ABC, "R4 fall ignored", got, 16'h0ABC);
        wr(8, 16'h000A); wr(1, 16'h0222); cc_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h0ABC, "R4 rise ignored", got, 16'h0ABC);
        cc_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h0222, "R4 capture fall", got, 16'h0222);
        wr(8, 16'h000B); wr(1, 16'h0333); cc_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h0333, "R4 both rise", got, 16'h0333);
        wr(1, 16'h0444); cc_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h0444, "R4 both fall", got, 16'h0444);
        wr(8, 16'h0001); wr(0, 16'h5555); cc_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd(4, got); chk(got == 16'h5555, "R5 select t0", got, 16'h5555);
        cc_in[0] = 1'b0;
        wr(12, 16'h000F);
        chk(irq == 0, "R12 clear all", irq, 0);

        // R6/R7/R8: compare modes
        wr(8, 16'h0000); wr(2, 16'hFFF0);
        wr(5, 16'hFFF4); wr(9, 16'h0004);
        wr(6, 16'hFFF4); wr(10, 16'h0006);
        wr(7, 16'hFFF4); wr(11, 16'h0005);
        wr(12, 16'h000F); wr(0, 16'hFFF0);
        run(0, 10, 2'd0);
        chk(irq[3:1] == 3'b111, "R6 R8 first match", irq, 4'hE);
        chk(cc_out[3] == 1'b1, "R7 toggle 1", cc_out, 4'h8);
        wr(12, 16'h000F); wr(0, 16'hFFF0);
        run(0, 10, 2'd0);
        chk(irq[1] == 1'b1, "R6 every match", irq, 4'hA);
        chk(irq[2] == 1'b0, "R8 once per period", irq, 4'hA);
        chk(cc_out[3] == 1'b0, "R7 toggle 2", cc_out, 0);
        wr(12, 16'h000F);
        run(0, 10, 2'd0);
        chk(irq[2] == 1'b1, "R8 rearm after overflow", irq, 4'hE);
        chk(cc_out[3] == 1'b1, "R7 toggle 3", cc_out, 4'h8);
        wr(12, 16'h0002);
        chk(irq == 4'b1100, "R12 partial clear", irq, 4'hC);

        // R9: set on match, clear on overflow, coincidence
        wr(4, 16'hFFF6); wr(8, 16'h0007); wr(0, 16'hFFF0);
        run(0, 8, 2'd0);
        chk(cc_out[0] == 1'b1, "R9 set", cc_out, 1);
        run(0, 7, 2'd0);
        chk(cc_out[0] == 1'b1, "R9 held", cc_out, 1);
        run(0, 1, 2'd0);
        chk(cc_out[0] == 1'b0, "R9 clear on overflow", cc_out, 0);
        rd(0, got); chk(got == 16'hFFF0, "R3 reload t0", got, 16'hFFF0);
        wr(4, 16'hFFF0); wr(0, 16'hFFFE);
        run(0, 2, 2'd0);
        chk(cc_out[0] == 1'b1, "R9 match beats overflow", cc_out, 1);

        // R10: paired channels
        wr(10, 16'h0000); wr(11, 16'h0000);
        wr(4, 16'hFFF2); wr(8, 16'h0015); wr(5, 16'hFFF5);
        p0 = cc_out[0]; p1 = cc_out[1];
        wr(0, 16'hFFF0);
        run(0, 3, 2'd0);
        chk(cc_out[0] == ~p0, "R10 even match", cc_out[0], ~p0);
        run(0, 3, 2'd0);
        chk(cc_out[0] == p0, "R10 odd match", cc_out[0], p0);
        chk(cc_out[1] == p1, "R10 odd pin held", cc_out[1], p1);
        wr(5, 16'hFFF2); wr(0, 16'hFFF0);
        run(0, 3, 2'd0);
        chk(cc_out[0] == ~p0, "R10 both same cycle", cc_out[0], ~p0);

        // R11: stalled timer
        wr(7, 16'h0040); wr(11, 16'h0005); wr(12, 16'h000F);
        p3 = cc_out[3];
        wr(0, 16'h0040);
        repeat (10) @(negedge clk);
        chk(cc_out[3] == p3 && irq[3] == 1'b0, "R11 no action when stopped", {cc_out[3], irq[3]}, {p3, 1'b0});
        wr(0, 16'h003F);
        run(0, 8, 2'd3);
        rd(0, got); chk(got == 16'h0040, "R11 one tick", got, 16'h0040);
        chk(cc_out[3] == ~p3, "R11 single toggle between ticks", cc_out[3], ~p3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule